// File: doc/BRIEF.md
# Domain Access Gate

This block decides, for one memory access at a time, whether the access may go ahead or must fault. Each access arrives with the attributes of its already translated entry: a 4-bit domain number, a 2-bit permission code and an execute-never flag. It also carries the kind of access (read, write or instruction fetch) and whether the requester runs in privileged mode. The answer is an allow flag plus a 2-bit fault code, registered, so it appears one clock after the request.

A 32-bit control register holds one 2-bit mode field per domain. A domain may be set to deny everything, to act as a client that obeys the per-page permission code, or to act as a manager that ignores the page permissions and the execute-never flag. The register is loaded as a whole through a write strobe and can be read back at all times. After reset every field is zero, so every domain denies access until software loads the register.

Top module: `dom_access_gate`

## Requirements
- R1: After reset the control register reads 0 on `cfg_rdata`, so any valid request then returns a domain fault (code 1).
- R2: With `cfg_we` high at a rising edge, `cfg_wdata` is loaded; domain d uses bits [2d+1:2d]. A request made in the same cycle as the write is judged with the old register value.
- R3: Mode field 00 (deny) returns a domain fault (code 1), whatever the permission code, execute-never flag, access kind or privilege.
- R4: Mode field 10 is reserved and is handled like deny: domain fault (code 1).
- R5: Mode field 11 (manager) allows the access (allow 1, code 0) for every permission code, execute-never value, kind and privilege.
- R6: In a client domain (mode 01), permission code 00 denies all; 01 allows privileged reads and writes only; 10 allows privileged reads and writes plus user reads; 11 allows everything. A denied access returns a permission fault (code 3).
- R7: In a client domain, an instruction fetch with execute-never set returns an execute fault (code 2); this wins over a permission fault, and a domain fault wins over both. Execute-never has no effect on reads or writes.
- R8: Access kind encoding: 00 read, 01 write, 10 fetch, 11 also fetch. A fetch needs the same permission as a read.
- R9: The response appears one clock after the request: `rsp_valid` equals the previous cycle's `req_valid`; without a request, `rsp_allow` and `rsp_fault` are 0. `rsp_allow` is 1 exactly when the fault code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Load strobe for the control register |
| cfg_wdata | input | 32 | New control register value |
| cfg_rdata | output | 32 | Current control register value |
| req_valid | input | 1 | An access is presented this cycle |
| req_domain | input | 4 | Domain number of the translated entry |
| req_perm | input | 2 | Permission code of the entry |
| req_xn | input | 1 | Entry is not executable |
| req_kind | input | 2 | Access kind |
| req_priv | input | 1 | Requester is privileged |
| rsp_valid | output | 1 | Response is present |
| rsp_allow | output | 1 | Access may proceed |
| rsp_fault | output | 2 | 0 none, 1 domain, 2 execute, 3 permission |

## Verification
The only state is the control register, so a corrupted or misloaded field shows as a wrong verdict on the very next request that names that domain, one clock after it is presented, and as a wrong readback value at once. A field picked from the wrong bit pair shows up as the verdict of a neighbouring domain's mode. The bench loads a register pattern that puts every mode in several domains and walks permission codes, kinds and privilege levels against each, so a mis-indexed field or a wrong priority changes the fault code of at least one vector.

// File: rtl/dag_pkg.sv
package dag_pkg;

   typedef enum logic [1:0] {
      ACC_READ      = 2'b00,
      ACC_WRITE     = 2'b01,
      ACC_FETCH     = 2'b10,
      ACC_FETCH_ALT = 2'b11
   } acc_kind_e;

   typedef enum logic [1:0] {
      FLT_NONE   = 2'd0,
      FLT_DOMAIN = 2'd1,
      FLT_EXEC   = 2'd2,
      FLT_PERM   = 2'd3
   } fault_e;

   typedef enum logic [1:0] {
      DOM_DENY    = 2'b00,
      DOM_CLIENT  = 2'b01,
      DOM_RSVD    = 2'b10,
      DOM_MANAGER = 2'b11
   } dom_mode_e;

   typedef enum logic [1:0] {
      AP_NONE       = 2'b00,
      AP_PRIV       = 2'b01,
      AP_PRIV_UREAD = 2'b10,
      AP_FULL       = 2'b11
   } ap_e;

endpackage

// File: rtl/dag_ctrl_reg.sv
module dag_ctrl_reg #(
   parameter int REG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] q
);

   if (REG_W < 2) begin : g_bad_width
      $error("dag_ctrl_reg: REG_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (we) q <= wdata;
   end

   // R2
   load_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (q == $past(wdata)));

   // R2
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));

endmodule

// File: rtl/dag_domain_sel.sv
module dag_domain_sel
   import dag_pkg::*;
#(
   parameter int NUM_DOMAINS = 16,
   parameter int FIELD_W     = 2,
   localparam int IDX_W      = $clog2(NUM_DOMAINS),
   localparam int REG_W      = NUM_DOMAINS * FIELD_W
) (
   input  logic [REG_W-1:0] ctrl,
   input  logic [IDX_W-1:0] idx,
   output dom_mode_e        mode
);

   if (FIELD_W != 2) begin : g_bad_field
      $error("dag_domain_sel: FIELD_W must be 2");
   end
   if (NUM_DOMAINS < 2 || (NUM_DOMAINS & (NUM_DOMAINS - 1)) != 0) begin : g_bad_count
      $error("dag_domain_sel: NUM_DOMAINS must be a power of two");
   end

   logic [FIELD_W-1:0] fields [NUM_DOMAINS];

   for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_split
      assign fields[d] = ctrl[d*FIELD_W +: FIELD_W];
   end

   assign mode = dom_mode_e'(fields[idx]);

endmodule

// File: rtl/dag_perm_eval.sv
module dag_perm_eval
   import dag_pkg::*;
(
   input  ap_e       ap,
   input  logic      priv,
   input  acc_kind_e kind,
   output logic      perm_ok
);

   logic is_write;
   assign is_write = (kind == ACC_WRITE);

   always_comb begin
      unique case (ap)
         AP_NONE:       perm_ok = 1'b0;
         AP_PRIV:       perm_ok = priv;
         AP_PRIV_UREAD: perm_ok = priv | ~is_write;
         AP_FULL:       perm_ok = 1'b1;
         default:       perm_ok = 1'b0;
      endcase
   end

   // R6
   always_comb begin
      if (ap == AP_NONE) no_access_denies_chk: assert (!perm_ok);
   end

endmodule

// File: rtl/dom_access_gate.sv
module dom_access_gate
   import dag_pkg::*;
#(
   parameter int NUM_DOMAINS = 16,
   parameter int FIELD_W     = 2,
   parameter bit OUT_REG     = 1'b1,
   localparam int IDX_W      = $clog2(NUM_DOMAINS),
   localparam int REG_W      = NUM_DOMAINS * FIELD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [REG_W-1:0] cfg_wdata,
   output logic [REG_W-1:0] cfg_rdata,
   input  logic             req_valid,
   input  logic [IDX_W-1:0] req_domain,
   input  logic [1:0]       req_perm,
   input  logic             req_xn,
   input  logic [1:0]       req_kind,
   input  logic             req_priv,
   output logic             rsp_valid,
   output logic             rsp_allow,
   output logic [1:0]       rsp_fault
);

   logic [REG_W-1:0] ctrl_q;
   dom_mode_e        mode;
   logic             perm_ok;
   logic             is_fetch;
   fault_e           fault_d;
   logic             allow_d;

   dag_ctrl_reg #(.REG_W(REG_W)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .q     (ctrl_q)
   );

   assign cfg_rdata = ctrl_q;

   dag_domain_sel #(.NUM_DOMAINS(NUM_DOMAINS), .FIELD_W(FIELD_W)) u_sel (
      .ctrl (ctrl_q),
      .idx  (req_domain),
      .mode (mode)
   );

   dag_perm_eval u_perm (
      .ap      (ap_e'(req_perm)),
      .priv    (req_priv),
      .kind    (acc_kind_e'(req_kind)),
      .perm_ok (perm_ok)
   );

   assign is_fetch = req_kind[1];

   always_comb begin
      unique case (mode)
         DOM_MANAGER: fault_d = FLT_NONE;
         DOM_CLIENT: begin
            if (is_fetch && req_xn) fault_d = FLT_EXEC;
            else if (!perm_ok)      fault_d = FLT_PERM;
            else                    fault_d = FLT_NONE;
         end
         default: fault_d = FLT_DOMAIN;
      endcase
   end

   assign allow_d = req_valid && (fault_d == FLT_NONE);

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_allow <= 1'b0;
            rsp_fault <= FLT_NONE;
         end else begin
            rsp_valid <= req_valid;
            rsp_allow <= allow_d;
            rsp_fault <= req_valid ? fault_d : FLT_NONE;
         end
      end

      // R9
      valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid |=> rsp_valid);

      // R9
      idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !req_valid |=> (!rsp_valid && !rsp_allow && rsp_fault == FLT_NONE));

      // R5
      manager_allows_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && mode == DOM_MANAGER) |=> (rsp_allow && rsp_fault == FLT_NONE));

      // R3
      deny_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && (mode == DOM_DENY || mode == DOM_RSVD)) |=> (!rsp_allow && rsp_fault == FLT_DOMAIN));

      // R7
      client_xn_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && mode == DOM_CLIENT && is_fetch && req_xn) |=> (rsp_fault == FLT_EXEC));

      // R6
      client_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && mode == DOM_CLIENT && !is_fetch && !perm_ok) |=> (rsp_fault == FLT_PERM));
   end else begin : g_out_comb
      assign rsp_valid = req_valid;
      assign rsp_allow = allow_d;
      assign rsp_fault = req_valid ? fault_d : FLT_NONE;
   end

endmodule

// File: tb/dom_access_gate_tb.sv
module dom_access_gate_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        req_valid = 1'b0;
   logic [3:0]  req_domain = '0;
   logic [1:0]  req_perm = '0;
   logic        req_xn = 1'b0;
   logic [1:0]  req_kind = '0;
   logic        req_priv = 1'b0;
   logic        rsp_valid;
   logic        rsp_allow;
   logic [1:0]  rsp_fault;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dom_access_gate u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_domain(req_domain),
      .req_perm(req_perm), .req_xn(req_xn), .req_kind(req_kind),
      .req_priv(req_priv), .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
      .rsp_fault(rsp_fault)
   );

   // Register pattern: domain d has mode d%4 (deny, client, reserved, manager).
   localparam logic [31:0] PATTERN = 32'hE4E4_E4E4;

   // {domain, perm, xn, kind, priv, expected fault}
   localparam logic [11:0] VEC [NVEC] = '{
      {4'd0,  2'd3, 1'b0, 2'd0, 1'b1, 2'd1},  // R3
      {4'd8,  2'd3, 1'b0, 2'd1, 1'b0, 2'd1},  // R3
      {4'd2,  2'd3, 1'b0, 2'd0, 1'b1, 2'd1},  // R4
      {4'd14, 2'd0, 1'b1, 2'd2, 1'b1, 2'd1},  // R4
      {4'd3,  2'd0, 1'b1, 2'd2, 1'b0, 2'd0},  // R5
      {4'd7,  2'd0, 1'b0, 2'd1, 1'b0, 2'd0},  // R5
      {4'd11, 2'd2, 1'b1, 2'd3, 1'b0, 2'd0},  // R5
      {4'd1,  2'd0, 1'b0, 2'd0, 1'b1, 2'd3},  // R6
      {4'd1,  2'd1, 1'b0, 2'd0, 1'b1, 2'd0},  // R6
      {4'd1,  2'd1, 1'b0, 2'd1, 1'b0, 2'd3},  // R6
      {4'd5,  2'd1, 1'b0, 2'd0, 1'b0, 2'd3},  // R6
      {4'd5,  2'd2, 1'b0, 2'd0, 1'b0, 2'd0},  // R6
      {4'd5,  2'd2, 1'b0, 2'd1, 1'b0, 2'd3},  // R6
      {4'd9,  2'd2, 1'b0, 2'd1, 1'b1, 2'd0},  // R6
      {4'd9,  2'd3, 1'b0, 2'd1, 1'b0, 2'd0},  // R6
      {4'd13, 2'd3, 1'b0, 2'd0, 1'b0, 2'd0},  // R6
      {4'd13, 2'd3, 1'b1, 2'd2, 1'b1, 2'd2},  // R7
      {4'd1,  2'd0, 1'b1, 2'd2, 1'b0, 2'd2},  // R7
      {4'd9,  2'd3, 1'b1, 2'd0, 1'b0, 2'd0},  // R7
      {4'd9,  2'd3, 1'b1, 2'd1, 1'b0, 2'd0},  // R7
      {4'd5,  2'd2, 1'b0, 2'd2, 1'b0, 2'd0},  // R8
      {4'd5,  2'd1, 1'b0, 2'd2, 1'b0, 2'd3},  // R8
      {4'd5,  2'd1, 1'b0, 2'd3, 1'b1, 2'd0},  // R8
      {4'd13, 2'd0, 1'b0, 2'd2, 1'b1, 2'd3}   // R8
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [3:0] d, input logic [1:0] p, input logic x,
                       input logic [1:0] k, input logic pv);
      @(negedge clk);
      req_valid = 1'b1; req_domain = d; req_perm = p;
      req_xn = x; req_kind = k; req_priv = pv;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic check_rsp(input string req, input logic [1:0] exp_fault);
      check({req, " valid"}, {31'd0, rsp_valid}, 32'd1);
      check({req, " fault"}, {30'd0, rsp_fault}, {30'd0, exp_fault});
      check({req, " allow"}, {31'd0, rsp_allow}, {31'd0, exp_fault == 2'd0});
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 rdata", cfg_rdata, 32'd0);
      check("R9 reset valid", {31'd0, rsp_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      send(4'd5, 2'd3, 1'b0, 2'd0, 1'b1);
      check_rsp("R1 unconfigured", 2'd1);
      send(4'd15, 2'd3, 1'b0, 2'd1, 1'b1);
      check_rsp("R1 unconfigured", 2'd1);

      // R9 idle cycle gives quiet outputs
      @(negedge clk);
      check("R9 idle valid", {31'd0, rsp_valid}, 32'd0);
      check("R9 idle fault", {30'd0, rsp_fault}, 32'd0);

      // R2 load the pattern and read back
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = PATTERN;
      @(negedge clk);
      cfg_we = 1'b0;
      check("R2 rdata", cfg_rdata, PATTERN);

      for (int i = 0; i < NVEC; i++) begin
         send(VEC[i][11:8], VEC[i][7:6], VEC[i][5], VEC[i][4:3], VEC[i][2]);
         check_rsp($sformatf("vector %0d", i), VEC[i][1:0]);
      end

      // R2 same-cycle write uses old register value
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = 32'hFFFF_FFFF;
      req_valid = 1'b1; req_domain = 4'd0; req_perm = 2'd3;
      req_xn = 1'b0; req_kind = 2'd0; req_priv = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0; req_valid = 1'b0;
      check_rsp("R2 old value", 2'd1);
      send(4'd0, 2'd0, 1'b1, 2'd2, 1'b0);
      check_rsp("R2 new value", 2'd0);

      // R2 field position: only domain 6 made client, others deny
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = 32'h0000_1000;
      @(negedge clk);
      cfg_we = 1'b0;
      send(4'd6, 2'd3, 1'b0, 2'd1, 1'b0);
      check_rsp("R2 field d6", 2'd0);
      send(4'd7, 2'd3, 1'b0, 2'd1, 1'b0);
      check_rsp("R2 field d7", 2'd1);
      send(4'd5, 2'd3, 1'b0, 2'd1, 1'b0);
      check_rsp("R2 field d5", 2'd1);

      // R1 reset clears the register again
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 re-reset rdata", cfg_rdata, 32'd0);
      rst_n = 1'b1;

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule